// File: doc/BRIEF.md
# Run-Length Compressing Capture Front End

This block sits between a probe signal and the word memory of a capture scope. It packs stretches of unchanged input into run-length records. A buffer of fixed depth then covers a much longer span of time than it could with one word per clock. Every accepted sample either becomes a literal word holding the new value, or extends a pending run. A pending run is written out as a single run word when the value changes, when the run reaches a configurable cap, when a trigger sample arrives, or when the capture's final sample arrives.

Samples enter on a valid/ready stream, each with a trigger flag and a last flag. Words leave on a second valid/ready stream towards the memory writer. Back-pressure works as follows:
- A word on the output is held unchanged until it is taken.
- One input sample can produce two words: a flushed run followed by its literal. While the second of these waits, the input is refused.
- The input ready depends combinationally on the output ready, and on nothing else at the same edge.

The last flag ends a capture. The sample after it starts a fresh capture.

Top module: `rle_capture_front`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1, and no run is pending.
- R2: The first sample accepted after reset, or after a sample flagged last, is emitted as a literal even if it equals the previous value.
- R3: A literal word has bit WORD_W-1 = 0, bit DATA_W = trigger flag and bits DATA_W-1:0 = sample. An accepted sample whose value differs from the previous sample is emitted as a literal. An unflagged sample equal to the previous one emits no word at the time it is accepted.
- R4: A run word has bit WORD_W-1 = 1, and bits WORD_W-2:0 hold the number of repeated clocks minus one. A pending run is emitted immediately before the literal that ends it.
- R5: When a run reaches MAX_STEP repeated clocks, a run word with count field MAX_STEP-1 is emitted at once, and counting restarts from zero. No run word ever carries a count field above MAX_STEP-1.
- R6: A sample flagged trigger is always emitted as a literal with bit DATA_W set. Samples not flagged trigger have that bit clear.
- R7: A sample flagged last is always emitted as a literal, after any pending run. The word sequence of a capture therefore never ends in a run word.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_word` stays stable. `in_ready` is 0 while the output slot is occupied and not being taken, or while a second word is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample accepted at this edge if valid |
| in_data | input | DATA_W | Probe sample |
| in_trig | input | 1 | Sample coincides with the trigger |
| in_last | input | 1 | Final sample of the capture |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Downstream takes the word at this edge |
| out_word | output | DATA_W+2 | Literal or run word |

## Verification
The assertions assume the following about the inputs:
- Upstream follows the handshake: it holds a sample, with its flags, until that sample is accepted.
- A last flag is set only on a sample that is actually accepted.
- Resets happen at clock edges.

The stimulus keeps within these assumptions. It drives each sample at a falling edge and holds it until `in_ready` is seen high before a rising edge. It sweeps run lengths across and beyond several multiples of a small cap. It repeats the sweeps with the output ready toggled by a shift register, so that the stall and two-word paths are both exercised.

// File: rtl/rle_pkg.sv
package rle_pkg;
  // Kind tag carried in the top bit of every emitted word.
  typedef enum logic {
    RLE_LIT = 1'b0,
    RLE_RUN = 1'b1
  } rle_kind_e;
endpackage

// File: rtl/rle_change_det.sv
module rle_change_det #(
  parameter int DATA_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              restart,
  input  logic [DATA_W-1:0] data,
  output logic              fresh,
  output logic              same
);
  logic [DATA_W-1:0] prev_q;
  logic              have_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (load) begin
      prev_q <= data;
      have_q <= !restart;
    end
  end

  assign fresh = !have_q;
  assign same  = have_q && (data == prev_q);

  // R2: a sample closing a capture leaves the detector fresh.
  a_r2_restart_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    load && restart |=> fresh);
endmodule

// File: rtl/rle_run_ctr.sv
module rle_run_ctr #(
  parameter int MAX_STEP = 768,
  localparam int CNT_W = $clog2(MAX_STEP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             at_cap
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (inc)   cnt <= cnt + CNT_W'(1);
  end

  assign at_cap = (cnt == CNT_W'(MAX_STEP - 1));

  // R5: the pending count never reaches the cap without being emitted.
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_STEP - 1));
endmodule

// File: rtl/rle_word_buf.sv
module rle_word_buf #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_a,
  input  logic [W-1:0] word_a,
  input  logic         push_b,
  input  logic [W-1:0] word_b,
  output logic         can_take,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_word
);
  logic         pend_v;
  logic [W-1:0] pend_w;
  logic         free;

  assign free     = !out_valid || out_ready;
  assign can_take = free && !pend_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      pend_v    <= 1'b0;
      pend_w    <= '0;
    end else if (pend_v && free) begin
      out_word  <= pend_w;
      out_valid <= 1'b1;
      pend_v    <= 1'b0;
    end else if (push_a) begin
      out_word  <= word_a;
      out_valid <= 1'b1;
      pend_v    <= push_b;
      pend_w    <= word_b;
    end else if (free) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a stalled word is held unchanged.
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));
  // R8: a waiting second word reaches the output once the slot frees.
  a_r8_pend_moves: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v && out_ready |=> out_valid && !pend_v);
endmodule

// File: rtl/rle_capture_front.sv
module rle_capture_front #(
  parameter int DATA_W   = 30,
  parameter int MAX_STEP = 768,
  localparam int WORD_W  = DATA_W + 2,
  localparam int CNT_W   = $clog2(MAX_STEP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_trig,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);
  import rle_pkg::*;

  logic             accept, fresh, same, force_lit;
  logic             rep, cap, lit, flush, at_cap;
  logic [CNT_W-1:0] cnt;
  logic [WORD_W-1:0] lit_word, run_flush, run_cap, word_a;

  assign accept    = in_valid && in_ready;
  assign force_lit = fresh || in_trig || in_last;
  assign rep       = accept && !force_lit && same;
  assign cap       = rep && at_cap;
  assign lit       = accept && !rep;
  assign flush     = lit && (cnt != '0);

  assign lit_word  = {RLE_LIT, in_trig, in_data};
  assign run_flush = {RLE_RUN, (WORD_W-1)'(cnt - CNT_W'(1))};
  assign run_cap   = {RLE_RUN, (WORD_W-1)'(MAX_STEP - 1)};
  assign word_a    = cap ? run_cap : (flush ? run_flush : lit_word);

  rle_change_det #(.DATA_W(DATA_W)) u_det (
    .clk(clk), .rst_n(rst_n), .load(accept), .restart(in_last),
    .data(in_data), .fresh(fresh), .same(same)
  );

  rle_run_ctr #(.MAX_STEP(MAX_STEP)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc(rep && !cap), .clr(lit || cap),
    .cnt(cnt), .at_cap(at_cap)
  );

  rle_word_buf #(.W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .push_a(cap || lit), .word_a(word_a),
    .push_b(flush), .word_b(lit_word),
    .can_take(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  // R2: a fresh capture never carries a pending run.
  a_r2_fresh_no_run: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> cnt == '0);
  // R6: a trigger sample always produces output on the next cycle.
  a_r6_trig_emits: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_trig |=> out_valid);
  // R7: a final sample always produces output and clears the run.
  a_r7_last_emits: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_last |=> out_valid && cnt == '0);
  // R5: no run word exceeds the cap.
  a_r5_run_len: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_word[WORD_W-1] |-> out_word[WORD_W-2:0] <= (WORD_W-1)'(MAX_STEP - 1));
endmodule

// File: tb/tb_rle_capture_front.sv
module tb_rle_capture_front;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int MS = 4;
  localparam int WW = DW + 2;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n, in_valid, in_ready, in_trig, in_last;
  logic          out_valid, out_ready;
  logic [DW-1:0] in_data;
  logic [WW-1:0] out_word;

  rle_capture_front #(.DATA_W(DW), .MAX_STEP(MS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_trig(in_trig), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  logic [WW-1:0] exp_q[$];
  int checks = 0;
  int fails = 0;
  bit bp_mode = 0;
  bit mon_on = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [WW-1:0] last_popped = '0;

  task automatic check(bit ok, string req, logic [WW-1:0] act, logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected words of one block: value v held for n clocks, the first
  // sample possibly flagged trigger.
  task automatic push_block(logic [DW-1:0] v, int n, bit trig);
    int caps = (n - 1) / MS;
    int rem  = (n - 1) % MS;
    exp_q.push_back({1'b0, trig, v});
    for (int i = 0; i < caps; i++) exp_q.push_back({1'b1, (WW-1)'(MS - 1)});
    if (rem > 0) exp_q.push_back({1'b1, (WW-1)'(rem - 1)});
  endtask

  task automatic send(logic [DW-1:0] v, bit trig, bit last);
    @(negedge clk);
    in_valid = 1'b1; in_data = v; in_trig = trig; in_last = last;
    forever begin
      #2;
      if (in_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 in_valid = 1'b0; in_trig = 1'b0; in_last = 1'b0;
  endtask

  task automatic block(logic [DW-1:0] v, int n, bit trig, bit last);
    push_block(v, n, trig);
    for (int i = 0; i < n; i++) send(v, (i == 0) ? trig : 1'b0, last && (i == n - 1));
  endtask

  task automatic drain_check();
    repeat (40) @(negedge clk);
    // R7: all expected words seen, and the capture closed on a literal.
    check(exp_q.size() == 0, "R7 queue", WW'(exp_q.size()), '0);
    check(last_popped[WW-1] == 1'b0, "R7 tail", last_popped, {1'b0, last_popped[WW-2:0]});
  endtask

  task automatic capture_pair();
    // Sweep of run lengths across several multiples of the cap (R3, R4, R5).
    for (int n = 1; n <= 13; n++) block(DW'(n * 37 + 5), n, 1'b0, 1'b0);
    // R6: trigger on a value equal to the previous one stays a literal.
    block(DW'(13 * 37 + 5), 3, 1'b1, 1'b0);
    block(8'hA5, 7, 1'b0, 1'b0);
    // R7: last sample equal to previous value still flushes and ends literal.
    block(8'hA5, 1, 1'b0, 1'b1);
    // R2: next capture opens with a literal even for an unchanged value.
    block(8'hA5, 2, 1'b0, 1'b0);
    block(8'h3C, 9, 1'b1, 1'b0);
    block(8'h3C, 1, 1'b0, 1'b1);
    drain_check();
  endtask

  // Output monitor: sets ready at each falling edge, then samples.
  bit was_stalled = 0;
  logic [WW-1:0] stall_word = '0;
  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
      #1;
      if (mon_on) begin
        if (was_stalled)
          check(out_valid && out_word == stall_word, "R8 stall", out_word, stall_word);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R3 extra word", out_word, '0);
          end else begin
            logic [WW-1:0] e;
            string tag;
            e = exp_q.pop_front();
            if (e[WW-1]) tag = (e[WW-2:0] == (WW-1)'(MS - 1)) ? "R5 cap run" : "R4 flushed run";
            else         tag = e[DW] ? "R6 trigger literal" : "R3 literal";
            check(out_word == e, tag, out_word, e);
          end
          last_popped = out_word;
        end
        was_stalled = out_valid && !out_ready;
        stall_word  = out_word;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_trig = 1'b0; in_last = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    // R1: reset state.
    check(out_valid == 1'b0, "R1 out_valid", WW'(out_valid), '0);
    check(in_ready == 1'b1, "R1 in_ready", WW'(in_ready), WW'(1));
    rst_n = 1'b1;
    mon_on = 1'b1;
    capture_pair();
    bp_mode = 1'b1;
    capture_pair();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule